// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

The block joins two 18-bit three-state buses, A and B, and carries data across in either direction. Each direction has one storage element and three controls: a latch enable, a data clock and an output enable. With the latch enable high the path is transparent, so the far bus follows the near bus at once. With the latch enable low the path holds its stored word. A high-to-low transition of that direction's data clock captures a fresh word. The output enable decides whether the block drives the far bus or releases it.

The A-to-B output enable is active high. The B-to-A output enable is active low. A system clock samples the data clocks and the storage elements. A data-clock falling edge is recognised in the first system-clock cycle in which the data clock reads low after it read high. The word captured is the one on the near bus in that cycle.

Top module: `bus_xcvr18`

## Requirements
- R1: With `le_ab_i` high and `oe_ab_i` high, `b_io` equals `a_io` in the same cycle, with no clock edge in between.
- R2: With `le_ab_i` low and no falling edge seen on `clk_ab_i`, `b_io` keeps its stored word however `a_io` changes. A rising edge of `clk_ab_i` captures nothing.
- R3: With `le_ab_i` low, the first `clk_i` rising edge at which `clk_ab_i` is sampled low, after it was sampled high at the edge before, stores `a_io`. The stored word appears on `b_io` right after that edge.
- R4: With `oe_ab_i` low the block does not drive `b_io`, so an external driver alone sets its value.
- R5: The B-to-A path behaves as in R1 to R3, using `le_ba_i` and `clk_ba_i`, and drives `a_io` from `b_io`.
- R6: With `oe_ba_ni` high the block does not drive `a_io`. With `oe_ba_ni` low it drives it.
- R7: When the latch enable falls while the data clock is low, the path holds the last word it passed. When the latch enable falls while the data clock is high, the next falling edge of the data clock captures a new word.
- R8: While `rst_ni` is low both storage elements clear to zero. After reset, with both latch enables low, each enabled output drives all zeros.
- R9: When the latch enable is high in the same cycle that a data-clock falling edge is seen, the path is transparent. The word stored is the near-bus word of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock sampling data clocks and storage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_io | inout | 18 | Bus A, input of A-to-B and output of B-to-A |
| b_io | inout | 18 | Bus B, input of B-to-A and output of A-to-B |
| oe_ab_i | input | 1 | A-to-B output enable, active high |
| le_ab_i | input | 1 | A-to-B latch enable, high is transparent |
| clk_ab_i | input | 1 | A-to-B data clock, captures on falling edge |
| oe_ba_ni | input | 1 | B-to-A output enable, active low |
| le_ba_i | input | 1 | B-to-A latch enable, high is transparent |
| clk_ba_i | input | 1 | B-to-A data clock, captures on falling edge |

## Verification
A corrupt stored word shows on the driven bus in the first cycle after the faulty capture or hold, because the far bus reads the storage directly whenever the latch enable is low. A missed or extra edge detection shows as a stale or early word one system-clock cycle after the data clock falls. An inverted enable polarity shows as a bus value set by the external driver instead of the block, or as an undriven bus, in the same cycle. A broken transparent path shows within the cycle in which the near bus changes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;
  localparam int unsigned XCVR_NDIR = 2;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_PASS = 2'd1,
    MODE_CAPT = 2'd2
  } xcvr_mode_e;
endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign fall_o = sig_q & ~sig_i;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  xcvr_mode_e   mode_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    q_o <= '0;
    else if (mode_i != MODE_HOLD)   q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = XCVR_W,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  input  logic         le_i,
  input  logic         sclk_i,
  input  logic         oe_i,
  output logic [W-1:0] dout_o,
  output logic         den_o,
  output logic         fall_o
);
  xcvr_mode_e   mode;
  logic [W-1:0] q;

  xcvr_fall_det u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sclk_i),
    .fall_o (fall_o)
  );

  // transparency outranks an edge in the same cycle
  always_comb begin
    if (le_i)        mode = MODE_PASS;
    else if (fall_o) mode = MODE_CAPT;
    else             mode = MODE_HOLD;
  end

  xcvr_store #(.W(W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .d_i    (din_i),
    .q_o    (q)
  );

  assign dout_o = (mode == MODE_PASS) ? din_i : q;

  generate
    if (OE_LOW) begin : g_oe_low
      assign den_o = ~oe_i;
    end else begin : g_oe_high
      assign den_o = oe_i;
    end
  endgenerate
endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         oe_ab_i,
  input  logic         le_ab_i,
  input  logic         clk_ab_i,
  input  logic         oe_ba_ni,
  input  logic         le_ba_i,
  input  logic         clk_ba_i
);
  localparam int unsigned NDIR = XCVR_NDIR;

  logic [W-1:0] din_w [NDIR];
  logic [W-1:0] dat_w [NDIR];
  logic         den_w [NDIR];
  logic         fall_w[NDIR];
  logic         le_w  [NDIR];
  logic         sclk_w[NDIR];
  logic         oe_w  [NDIR];

  // index 0: A to B, index 1: B to A
  assign din_w[0]  = a_io;
  assign din_w[1]  = b_io;
  assign le_w[0]   = le_ab_i;
  assign le_w[1]   = le_ba_i;
  assign sclk_w[0] = clk_ab_i;
  assign sclk_w[1] = clk_ba_i;
  assign oe_w[0]   = oe_ab_i;
  assign oe_w[1]   = oe_ba_ni;

  generate
    for (genvar g = 0; g < NDIR; g++) begin : g_dir
      xcvr_path #(.W(W), .OE_LOW(g == 1)) u_path (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  (din_w[g]),
        .le_i   (le_w[g]),
        .sclk_i (sclk_w[g]),
        .oe_i   (oe_w[g]),
        .dout_o (dat_w[g]),
        .den_o  (den_w[g]),
        .fall_o (fall_w[g])
      );
    end
  endgenerate

  assign b_io = den_w[0] ? dat_w[0] : {W{1'bz}};
  assign a_io = den_w[1] ? dat_w[1] : {W{1'bz}};
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_io,
  input logic [W-1:0] b_io,
  input logic         oe_ab_i,
  input logic         le_ab_i,
  input logic         oe_ba_ni,
  input logic         le_ba_i,
  input logic [W-1:0] dat_ab,
  input logic [W-1:0] dat_ba,
  input logic         den_ab,
  input logic         den_ba,
  input logic         fall_ab,
  input logic         fall_ba
);
  // R1
  ab_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_ab_i && le_ab_i) |-> (b_io == a_io));

  // R2
  ab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_ab_i && !$past(le_ab_i) && !$past(fall_ab)) |-> $stable(dat_ab));

  // R3
  ab_capt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_ab_i && !$past(le_ab_i) && $past(fall_ab)) |-> (dat_ab == $past(a_io)));

  // R4
  ab_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ab_i |-> !den_ab);

  // R5
  ba_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_ba_i && !$past(le_ba_i) && !$past(fall_ba)) |-> $stable(dat_ba));

  // R5
  ba_capt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_ba_i && !$past(le_ba_i) && $past(fall_ba)) |-> (dat_ba == $past(b_io)));

  // R6
  ba_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ba_ni |-> !den_ba);

  // R7
  ab_le_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(le_ab_i) && !le_ab_i) |-> (dat_ab == $past(a_io)));
endmodule

bind bus_xcvr18 xcvr_chk #(.W(W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_io     (a_io),
  .b_io     (b_io),
  .oe_ab_i  (oe_ab_i),
  .le_ab_i  (le_ab_i),
  .oe_ba_ni (oe_ba_ni),
  .le_ba_i  (le_ba_i),
  .dat_ab   (dat_w[0]),
  .dat_ba   (dat_w[1]),
  .den_ab   (den_w[0]),
  .den_ba   (den_w[1]),
  .fall_ab  (fall_w[0]),
  .fall_ba  (fall_w[1])
);

// File: tb/test_bus_xcvr18.sv
module test_bus_xcvr18;
  localparam int unsigned W = 18;
  localparam time CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         oe_ab = 1'b1, le_ab = 1'b0, sclk_ab = 1'b0;
  logic         oe_ba_n = 1'b1, le_ba = 1'b0, sclk_ba = 1'b0;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  wire  [W-1:0] a_bus, b_bus;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  // external drivers back off whenever the block drives that side
  assign a_bus = oe_ba_n ? a_drv : {W{1'bz}};
  assign b_bus = !oe_ab  ? b_drv : {W{1'bz}};

  always #(CLK_P/2) clk = ~clk;

  bus_xcvr18 #(.W(W)) i_bus_xcvr18 (
    .clk_i(clk), .rst_ni(rst_n), .a_io(a_bus), .b_io(b_bus),
    .oe_ab_i(oe_ab), .le_ab_i(le_ab), .clk_ab_i(sclk_ab),
    .oe_ba_ni(oe_ba_n), .le_ba_i(le_ba), .clk_ba_i(sclk_ba)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; oe_ab = 1'b1; oe_ba_n = 1'b1; le_ab = 0; le_ba = 0;
    a_drv = 18'h3ffff;
    repeat (3) step();
    drive(); rst_n = 1'b1;
    step();
    chk("R8 ab after reset", b_bus, '0);
    drive(); oe_ab = 1'b0; oe_ba_n = 1'b0; b_drv = 18'h2aaaa;
    #1 chk("R8 ba after reset", a_bus, '0);
    drive(); oe_ab = 1'b1; oe_ba_n = 1'b1;
  endtask

  task automatic t_ab_pass();
    drive(); le_ab = 1; a_drv = 18'h12345;
    #1 chk("R1 pass first", b_bus, 18'h12345);
    #2 a_drv = 18'h0beef;
    #1 chk("R1 pass follow", b_bus, 18'h0beef);
  endtask

  task automatic t_ab_hold_low_clk();
    drive(); le_ab = 1; sclk_ab = 0; a_drv = 18'h11111;
    step();
    drive(); le_ab = 0; a_drv = 18'h22222;
    step(); chk("R7 le fall clk low", b_bus, 18'h11111);
    drive(); a_drv = 18'h33333;
    step(); chk("R2 hold", b_bus, 18'h11111);
    drive(); sclk_ab = 1; a_drv = 18'h04444;
    step(); chk("R2 rising edge no capture", b_bus, 18'h11111);
  endtask

  task automatic t_ab_capture();
    drive(); sclk_ab = 1; a_drv = 18'h05555;
    step();
    drive(); sclk_ab = 0; a_drv = 18'h16666;
    #1 chk("R3 before edge", b_bus, 18'h11111);
    step(); chk("R3 capture", b_bus, 18'h16666);
    drive(); a_drv = 18'h27777;
    step(); chk("R2 hold after capture", b_bus, 18'h16666);
  endtask

  task automatic t_ab_le_fall_clk_high();
    drive(); le_ab = 1; sclk_ab = 1; a_drv = 18'h08888;
    step();
    drive(); le_ab = 0; a_drv = 18'h19999;
    step(); chk("R7 le fall clk high holds", b_bus, 18'h08888);
    drive(); sclk_ab = 0; a_drv = 18'h2cccc;
    step(); chk("R7 later fall captures", b_bus, 18'h2cccc);
  endtask

  task automatic t_ab_prio();
    drive(); sclk_ab = 1; a_drv = 18'h00f0f;
    step();
    drive(); le_ab = 1; sclk_ab = 0; a_drv = 18'h3a5a5;
    #1 chk("R9 transparent wins", b_bus, 18'h3a5a5);
    step();
    drive(); le_ab = 0; a_drv = 18'h01234;
    step(); chk("R9 stored word", b_bus, 18'h3a5a5);
  endtask

  task automatic t_ab_off();
    drive(); oe_ab = 0; le_ab = 1; a_drv = 18'h3ffff; b_drv = 18'h00000;
    #1 chk("R4 b released", b_bus, 18'h00000);
    drive(); b_drv = 18'h15a5a;
    #1 chk("R4 external value", b_bus, 18'h15a5a);
    drive(); le_ab = 0;
  endtask

  task automatic t_ba();
    drive(); oe_ab = 0; oe_ba_n = 0; le_ba = 1; sclk_ba = 0; b_drv = 18'h2468a;
    #1 chk("R5 ba pass", a_bus, 18'h2468a);
    step();
    drive(); le_ba = 0; b_drv = 18'h13579;
    step(); chk("R5 ba hold", a_bus, 18'h2468a);
    drive(); sclk_ba = 1;
    step();
    drive(); sclk_ba = 0; b_drv = 18'h0abcd;
    step(); chk("R5 ba capture", a_bus, 18'h0abcd);
    drive(); oe_ba_n = 1; le_ba = 1; b_drv = 18'h3ffff; a_drv = 18'h00000;
    #1 chk("R6 a released", a_bus, 18'h00000);
    drive(); a_drv = 18'h2f0f0;
    #1 chk("R6 external value", a_bus, 18'h2f0f0);
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ab_pass();
    t_ab_hold_low_clk();
    t_ab_capture();
    t_ab_le_fall_clk_high();
    t_ab_prio();
    t_ab_off();
    t_ba();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule